// File: doc/BRIEF.md
# Two-Wire Register Slave with Auto-Increment

This block is a serial slave on a two-wire bus (SCL/SDA, open-drain). A system clock oversamples both lines through a short synchronizer. The slave then detects START and STOP conditions and the clock edges. The first byte after a START carries a 7-bit device address with the direction bit in its LSB. On a write, the next byte loads a starting subaddress, and each later data byte is stored at the current pointer, after which the pointer advances. A read first sets the pointer with a write, then uses a repeated START and the address with the read bit. The slave then streams registers to the master until the master declines a byte.

The register space is 64 byte-wide slots selected by subaddress bits 5:0. Only the slots marked in a parameterised, possibly gapped valid map hold storage. Four slots starting at subaddress 0x02 form a 32-bit group. Writes to this group go into shadow storage, and all four bytes become visible together only when the fourth byte is taken in order. Every slot is presented on a flat parallel output bus for the surrounding logic.

Top module: `i2cr_slave`

## Requirements
- R1: The first byte after START is compared in bits 7:1 with the device address (default 0x2A); bit 0 set means read. On a match the slave pulls SDA low on the ninth clock. On a mismatch it leaves SDA released and ignores the bus, with no acknowledge and no register change, until the next START.
- R2: The subaddress byte is accepted and acknowledged only when bits 7:6 are zero and bits 5:0 name a slot set in the valid map (default: 0x00 to 0x12 and 0x24). Otherwise the slave leaves SDA released on the ninth clock and returns to idle.
- R3: In a write, each data byte is stored at the pointer and acknowledged, and the pointer then advances by one. Slot i appears on `regs_o[8*i+7:8*i]`.
- R4: After a repeated START with the read bit, the slave sends the slot at the pointer MSB first. The pointer advances after each byte the master acknowledges. A valid-map gap below the top slot reads as 0x00.
- R5: In a read, once the pointer reaches the highest valid slot, every further byte repeats that slot's contents until the master NACKs.
- R6: A write byte whose pointer is not a valid slot (a gap, or past the highest slot) is not stored anywhere. The slave NACKs it and returns to idle.
- R7: A STOP at any point returns the slave to idle. A START at any point restarts the address phase. A partly received byte is then discarded.
- R8: Writes to slots 0x02 to 0x05 land in shadow storage. All four slots change together, in the cycle the byte to 0x05 is taken, and only when the bytes arrived in order 0x02, 0x03, 0x04, 0x05 within one transfer. Lone, out-of-order or interrupted group writes are acknowledged but never appear on `regs_o`.
- R9: The slave starts pulling SDA low only while SCL is low, and it releases SDA on the SCL falling edge that ends the acknowledge clock.
- R10: After reset all slots read zero and SDA is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad (wired-AND value) |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| regs_o | output | 512 | All 64 slots, slot i in bits 8*i+7:8*i |

## Verification
The bench sweeps every one of the 64 subaddresses, plus one with bit 6 set, as a single-byte write. It checks the acknowledge pattern and the whole register bus after each one. A design with a wrong map decode would acknowledge a gap or store into one, and one that ignored bits 7:6 would alias onto slot 1. Runs that cross the gap and run past the top slot are used to catch a slave that wraps or keeps storing instead of NACKing. Long reads at the top slot catch a pointer that wraps instead of repeating. The group is driven in order, partly, alone and out of order, and it is sampled between the third and fourth bytes, so a design that commits byte by byte is caught. Address mismatch, and a START in the middle of a data byte, catch a slave that keeps listening or stores a fragment.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_SUB,
        ST_SACK,
        ST_WDATA,
        ST_WACK,
        ST_RDATA,
        ST_MACK,
        ST_IGNORE
    } i2cr_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

    // highest set bit of a slot map, 0 when empty
    function automatic int top_index(input logic [63:0] map);
        int r;
        r = 0;
        for (int i = 0; i < 64; i++) begin
            if (map[i]) r = i;
        end
        return r;
    endfunction

endpackage

// File: rtl/i2cr_sync.sv
module i2cr_sync
    import i2cr_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t ev
);
    logic [STAGES-1:0] scl_sh, sda_sh;
    logic              scl_d, sda_d;
    logic              scl_s, sda_s;

    assign scl_s = scl_sh[STAGES-1];
    assign sda_s = sda_sh[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[STAGES-2:0], sda_i};
            scl_d  <= scl_s;
            sda_d  <= sda_s;
        end
    end

    always_comb begin
        ev.scl      = scl_s;
        ev.sda      = sda_s;
        ev.scl_rise = scl_s & ~scl_d;
        ev.scl_fall = ~scl_s & scl_d;
        ev.start    = scl_s & scl_d & sda_d & ~sda_s;
        ev.stop     = scl_s & scl_d & ~sda_d & sda_s;
    end

endmodule

// File: rtl/i2cr_regbank.sv
module i2cr_regbank #(
    parameter int          SUB_W     = 6,
    parameter int          DW        = 8,
    parameter logic [63:0] VALID_MAP = 64'h0000_0010_0007_FFFF,
    parameter int          GBASE     = 2,
    parameter int          GLEN      = 4,
    localparam int         NSLOT     = 2 ** SUB_W,
    localparam int         GCW       = $clog2(GLEN + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [SUB_W-1:0]    wr_addr,
    input  logic [DW-1:0]       wr_data,
    input  logic                abort,
    input  logic [SUB_W-1:0]    rd_addr,
    output logic [DW-1:0]       rd_data,
    output logic [NSLOT*DW-1:0] regs_flat
);
    logic [DW-1:0]  shadow [GLEN-1];
    logic [GCW-1:0] gcnt;
    logic           in_grp, accept, commit;
    int             gofs;

    always_comb begin
        gofs   = int'(wr_addr) - GBASE;
        in_grp = (int'(wr_addr) >= GBASE) && (int'(wr_addr) < GBASE + GLEN);
        accept = wr_en && in_grp && (gofs == 0 || gofs == int'(gcnt));
        commit = accept && (gofs == GLEN - 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gcnt <= '0;
            for (int k = 0; k < GLEN - 1; k++) shadow[k] <= '0;
        end else if (abort) begin
            gcnt <= '0;
        end else if (wr_en) begin
            if (accept) begin
                for (int k = 0; k < GLEN - 1; k++)
                    if (gofs == k) shadow[k] <= wr_data;
                gcnt <= commit ? '0 : GCW'(gofs + 1);
            end else begin
                gcnt <= '0;
            end
        end
    end

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        if (!VALID_MAP[i]) begin : g_none
            assign regs_flat[i*DW +: DW] = '0;
        end else if (i == GBASE + GLEN - 1) begin : g_glast
            logic [DW-1:0] q;
            always_ff @(posedge clk) begin
                if (rst)         q <= '0;
                else if (commit) q <= wr_data;
            end
            assign regs_flat[i*DW +: DW] = q;
        end else if (i >= GBASE && i < GBASE + GLEN - 1) begin : g_gsh
            logic [DW-1:0] q;
            always_ff @(posedge clk) begin
                if (rst)         q <= '0;
                else if (commit) q <= shadow[i-GBASE];
            end
            assign regs_flat[i*DW +: DW] = q;
        end else begin : g_plain
            logic [DW-1:0] q;
            always_ff @(posedge clk) begin
                if (rst)                                q <= '0;
                else if (wr_en && int'(wr_addr) == i)   q <= wr_data;
            end
            assign regs_flat[i*DW +: DW] = q;
        end
    end

    assign rd_data = regs_flat[int'(rd_addr)*DW +: DW];

endmodule

// File: rtl/i2cr_slave.sv
module i2cr_slave
    import i2cr_pkg::*;
#(
    parameter int          SUB_W       = 6,
    parameter logic [6:0]  DEV_ADDR    = 7'h2A,
    parameter logic [63:0] VALID_MAP   = 64'h0000_0010_0007_FFFF,
    parameter int          GBASE       = 2,
    parameter int          GLEN        = 4,
    parameter int          SYNC_STAGES = 2,
    localparam int         DW          = 8,
    localparam int         NSLOT       = 2 ** SUB_W,
    localparam int         TOP         = top_index(VALID_MAP)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                scl_i,
    input  logic                sda_i,
    output logic                sda_oe_o,
    output logic [NSLOT*DW-1:0] regs_o
);
    localparam logic [SUB_W:0] TOP_P = (SUB_W+1)'(TOP);

    bus_evt_t       ev;
    i2cr_state_e    state;
    logic [3:0]     cnt;
    logic [DW-1:0]  shreg, txbyte;
    logic           rw, mnak;
    logic [SUB_W:0] ptr;
    logic           ptr_ok, wr_en, byte_done;
    logic [SUB_W-1:0] wr_addr, rd_addr, rd_next;
    logic [DW-1:0]  rd_data;

    i2cr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .ev(ev)
    );

    always_comb begin
        ptr_ok    = !ptr[SUB_W] && VALID_MAP[ptr[SUB_W-1:0]];
        byte_done = ev.scl_fall && (cnt == 4'd8);
        wr_en     = (state == ST_WDATA) && byte_done && ptr_ok
                    && !ev.start && !ev.stop;
        wr_addr   = ptr[SUB_W-1:0];
        rd_next   = (ptr >= TOP_P) ? TOP_P[SUB_W-1:0] : ptr[SUB_W-1:0] + 1'b1;
        rd_addr   = (state == ST_MACK) ? rd_next : ptr[SUB_W-1:0];
    end

    i2cr_regbank #(
        .SUB_W(SUB_W), .DW(DW), .VALID_MAP(VALID_MAP),
        .GBASE(GBASE), .GLEN(GLEN)
    ) u_bank (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(shreg),
        .abort(ev.start | ev.stop),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .regs_flat(regs_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            shreg    <= '0;
            txbyte   <= '0;
            rw       <= 1'b0;
            mnak     <= 1'b0;
            ptr      <= '0;
            sda_oe_o <= 1'b0;
        end else if (ev.stop) begin
            state    <= ST_IDLE;
            sda_oe_o <= 1'b0;
        end else if (ev.start) begin
            state    <= ST_ADDR;
            cnt      <= '0;
            sda_oe_o <= 1'b0;
        end else begin
            // shift in on rising SCL during every receive phase
            if ((state == ST_ADDR || state == ST_SUB || state == ST_WDATA)
                && ev.scl_rise && cnt != 4'd8) begin
                shreg <= {shreg[DW-2:0], ev.sda};
                cnt   <= cnt + 4'd1;
            end
            unique case (state)
                ST_ADDR: if (byte_done) begin
                    if (shreg[7:1] == DEV_ADDR) begin
                        rw       <= shreg[0];
                        sda_oe_o <= 1'b1;
                        state    <= ST_AACK;
                    end else begin
                        state    <= ST_IGNORE;
                    end
                end
                ST_AACK: if (ev.scl_fall) begin
                    if (rw) begin
                        txbyte   <= {rd_data[DW-2:0], 1'b0};
                        sda_oe_o <= ~rd_data[DW-1];
                        cnt      <= 4'd1;
                        state    <= ST_RDATA;
                    end else begin
                        sda_oe_o <= 1'b0;
                        cnt      <= '0;
                        state    <= ST_SUB;
                    end
                end
                ST_SUB: if (byte_done) begin
                    if (shreg[DW-1:SUB_W] == '0 && VALID_MAP[shreg[SUB_W-1:0]]) begin
                        ptr      <= {1'b0, shreg[SUB_W-1:0]};
                        sda_oe_o <= 1'b1;
                        state    <= ST_SACK;
                    end else begin
                        state    <= ST_IDLE;
                    end
                end
                ST_SACK, ST_WACK: if (ev.scl_fall) begin
                    sda_oe_o <= 1'b0;
                    cnt      <= '0;
                    state    <= ST_WDATA;
                end
                ST_WDATA: if (byte_done) begin
                    if (ptr_ok) begin
                        ptr      <= ptr + 1'b1;
                        sda_oe_o <= 1'b1;
                        state    <= ST_WACK;
                    end else begin
                        state    <= ST_IDLE;
                    end
                end
                ST_RDATA: if (ev.scl_fall) begin
                    if (cnt != 4'd8) begin
                        sda_oe_o <= ~txbyte[DW-1];
                        txbyte   <= {txbyte[DW-2:0], 1'b0};
                        cnt      <= cnt + 4'd1;
                    end else begin
                        sda_oe_o <= 1'b0;
                        state    <= ST_MACK;
                    end
                end
                ST_MACK: begin
                    if (ev.scl_rise) mnak <= ev.sda;
                    if (ev.scl_fall) begin
                        if (mnak) begin
                            state <= ST_IGNORE;
                        end else begin
                            ptr      <= {1'b0, rd_next};
                            txbyte   <= {rd_data[DW-2:0], 1'b0};
                            sda_oe_o <= ~rd_data[DW-1];
                            cnt      <= 4'd1;
                            state    <= ST_RDATA;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/i2cr_slave_chk.sv
module i2cr_slave_chk
    import i2cr_pkg::*;
#(
    parameter int          SUB_W     = 6,
    parameter logic [63:0] VALID_MAP = 64'h0000_0010_0007_FFFF,
    parameter int          GBASE     = 2,
    parameter int          GLEN      = 4,
    localparam int         NSLOT     = 2 ** SUB_W,
    localparam int         TOP       = top_index(VALID_MAP)
) (
    input logic               clk,
    input logic               rst,
    input logic               scl_i,
    input logic               sda_oe_o,
    input logic [NSLOT*8-1:0] regs_o,
    input i2cr_state_e        state,
    input logic               ev_start,
    input logic               ev_stop,
    input logic               wr_en,
    input logic [SUB_W-1:0]   wr_addr,
    input logic [SUB_W:0]     ptr
);
    assert_reset_idle_R10: assert property (@(posedge clk)
        rst |=> (!sda_oe_o && state == ST_IDLE));

    assert_drive_scl_low_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe_o) |-> !scl_i);

    assert_stop_idle_R7: assert property (@(posedge clk) disable iff (rst)
        ev_stop |=> state == ST_IDLE);

    assert_start_addr_R7: assert property (@(posedge clk) disable iff (rst)
        (ev_start && !ev_stop) |=> state == ST_ADDR);

    assert_store_cause_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(regs_o) |-> $past(wr_en));

    assert_sub_valid_R2: assert property (@(posedge clk) disable iff (rst)
        state == ST_SACK |-> (!ptr[SUB_W] && VALID_MAP[ptr[SUB_W-1:0]]));

    assert_read_ptr_R5: assert property (@(posedge clk) disable iff (rst)
        state == ST_RDATA |-> int'(ptr) <= TOP);

    for (genvar k = 0; k < GLEN; k++) begin : g_grp
        assert_group_commit_R8: assert property (@(posedge clk) disable iff (rst)
            !$stable(regs_o[(GBASE+k)*8 +: 8])
                |-> $past(wr_en && int'(wr_addr) == GBASE + GLEN - 1));
    end

endmodule

bind i2cr_slave i2cr_slave_chk #(
    .SUB_W(SUB_W), .VALID_MAP(VALID_MAP), .GBASE(GBASE), .GLEN(GLEN)
) u_chk (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
    .regs_o(regs_o), .state(state), .ev_start(ev.start), .ev_stop(ev.stop),
    .wr_en(wr_en), .wr_addr(wr_addr), .ptr(ptr)
);

// File: tb/tb_i2cr_slave.sv
module tb_i2cr_slave;
    localparam logic [63:0] VMAP = 64'h0000_0010_0007_FFFF;
    localparam logic [6:0]  DEV  = 7'h2A;
    localparam int          Q    = 6;

    logic clk = 1'b0, rst = 1'b1;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic sda_oe;
    logic [511:0] regs_o;
    wire  sda_line = m_sda & ~sda_oe;

    int n_chk = 0, n_err = 0;
    logic [7:0] model [64];
    logic [7:0] gsh [4];
    int         gn;
    logic [7:0] wdat [16];
    logic [7:0] rbuf [16];

    always #5 clk = ~clk;

    i2cr_slave dut (.clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line),
                    .sda_oe_o(sda_oe), .regs_o(regs_o));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        int bad;
        bad = -1;
        for (int i = 0; i < 64; i++)
            if (bad < 0 && regs_o[i*8 +: 8] !== model[i]) bad = i;
        n_chk++;
        if (bad >= 0) begin
            n_err++;
            $display("FAIL %s: slot %0d actual=%h expected=%h", req, bad,
                     regs_o[bad*8 +: 8], model[bad]);
        end
    endtask

    function automatic logic valid(input int p);
        return p >= 0 && p < 64 && VMAP[p];
    endfunction

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wt(Q); m_scl = 1'b1; wt(2*Q);
        m_sda = 1'b0; wt(2*Q); m_scl = 1'b0; wt(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wt(Q); m_scl = 1'b1; wt(2*Q);
        m_sda = 1'b1; wt(2*Q);
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; wt(Q); m_scl = 1'b1; wt(2*Q); m_scl = 1'b0; wt(Q);
    endtask

    task automatic recv_bit(output logic b);
        m_sda = 1'b1; wt(Q); m_scl = 1'b1; wt(Q); b = sda_line;
        wt(Q); m_scl = 1'b0; wt(Q);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(b);
        ack = ~b;
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic give_ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin recv_bit(b); d[i] = b; end
        send_bit(~give_ack);
    endtask

    // model of the accepted data byte at slot p, following R3 and R8
    task automatic model_write(input int p, input logic [7:0] v);
        if (p >= 2 && p <= 5) begin
            if (p - 2 == 0 || p - 2 == gn) begin
                gsh[p-2] = v;
                gn = p - 1;
                if (p == 5) begin
                    for (int k = 0; k < 4; k++) model[2+k] = gsh[k];
                    gn = 0;
                end
            end else gn = 0;
        end else begin
            gn = 0;
            model[p] = v;
        end
    endtask

    function automatic logic [17:0] exp_ack(input int sub, input int n);
        logic [17:0] e;
        logic ok;
        e = '0; e[0] = 1'b1;
        ok = valid(sub); e[1] = ok;
        for (int i = 0; i < n; i++) begin
            ok = ok && valid(sub + i);
            e[2+i] = ok;
        end
        return e;
    endfunction

    task automatic wr_txn(input logic [7:0] sub, input int n, output logic [17:0] acks);
        logic a;
        acks = '0; gn = 0;
        bus_start();
        send_byte({DEV, 1'b0}, a); acks[0] = a;
        send_byte(sub, a);         acks[1] = a;
        for (int i = 0; i < n; i++) begin
            send_byte(wdat[i], a); acks[2+i] = a;
            if (a) model_write(int'(sub) + i, wdat[i]);
        end
        bus_stop();
    endtask

    task automatic rd_txn(input logic [7:0] sub, input int n);
        logic a;
        bus_start();
        send_byte({DEV, 1'b0}, a);
        send_byte(sub, a);
        bus_start();
        send_byte({DEV, 1'b1}, a);
        chk("R4 read address ack", 32'(a), 32'd1);
        for (int i = 0; i < n; i++) recv_byte(rbuf[i], i != n - 1);
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [17:0] acks;
        logic a;
        for (int i = 0; i < 64; i++) model[i] = 8'h00;
        for (int k = 0; k < 4; k++) gsh[k] = 8'h00;
        gn = 0;
        wt(5); rst = 1'b0; wt(5);

        // R10 reset state
        check_all("R10 reset slots");
        chk("R10 reset sda released", 32'(sda_oe), 32'd0);

        // R2/R3/R8 sweep of every subaddress as a single write
        for (int s = 0; s < 64; s++) begin
            wdat[0] = 8'((s * 37 + 11) ^ 8'h5A);
            wr_txn(8'(s), 1, acks);
            chk($sformatf("R2 sweep ack sub=%0d", s), 32'(acks[2:0]), 32'(exp_ack(s, 1)));
            check_all($sformatf("R3 R8 sweep store sub=%0d", s));
        end
        wdat[0] = 8'hC3;
        wr_txn(8'h41, 1, acks);
        chk("R2 upper bits set nack", 32'(acks[2:0]), 32'b001);
        check_all("R2 upper bits no alias");

        // R3 burst write
        for (int i = 0; i < 5; i++) wdat[i] = 8'(8'h90 + i * 3);
        wr_txn(8'h06, 5, acks);
        chk("R3 burst acks", 32'(acks[6:0]), 32'(exp_ack(6, 5)));
        check_all("R3 burst store");

        // R8 in-order group, sampled before the fourth byte
        bus_start(); gn = 0;
        send_byte({DEV, 1'b0}, a);
        send_byte(8'h02, a);
        for (int i = 0; i < 3; i++) begin
            send_byte(8'(8'hA1 + i), a);
            model_write(2 + i, 8'(8'hA1 + i));
        end
        check_all("R8 no partial commit");
        chk("R9 sda released after ack", 32'(sda_oe), 32'd0);
        send_byte(8'hA4, a); model_write(5, 8'hA4);
        check_all("R8 group committed");
        bus_stop();
        // interrupted group and out-of-order start
        wdat[0] = 8'h11; wdat[1] = 8'h22;
        wr_txn(8'h02, 2, acks);
        check_all("R8 interrupted group discarded");
        wdat[0] = 8'h33; wdat[1] = 8'h44; wdat[2] = 8'h55;
        wr_txn(8'h03, 3, acks);
        chk("R8 out-of-order acked", 32'(acks[4:0]), 32'b11111);
        check_all("R8 out-of-order discarded");

        // R4 burst read of the dense range
        rd_txn(8'h00, 16);
        for (int i = 0; i < 16; i++)
            chk($sformatf("R4 read slot %0d", i), 32'(rbuf[i]), 32'(model[i]));
        rd_txn(8'h11, 4);
        chk("R4 read 0x11", 32'(rbuf[0]), 32'(model[17]));
        chk("R4 read 0x12", 32'(rbuf[1]), 32'(model[18]));
        chk("R4 gap reads zero a", 32'(rbuf[2]), 32'd0);
        chk("R4 gap reads zero b", 32'(rbuf[3]), 32'd0);

        // R5 overrun on read repeats top slot
        rd_txn(8'h24, 5);
        for (int i = 0; i < 5; i++)
            chk($sformatf("R5 overrun byte %0d", i), 32'(rbuf[i]), 32'(model[36]));

        // R6 write overrun past top and into a gap
        wdat[0] = 8'h6E; wdat[1] = 8'h7F;
        wr_txn(8'h24, 2, acks);
        chk("R6 past top acks", 32'(acks[3:0]), 32'b0111);
        check_all("R6 past top not stored");
        wdat[0] = 8'h12; wdat[1] = 8'h34; wdat[2] = 8'h56;
        wr_txn(8'h11, 3, acks);
        chk("R6 gap acks", 32'(acks[4:0]), 32'b01111);
        check_all("R6 gap not stored");

        // R1 address mismatch
        bus_start();
        send_byte({7'h2B, 1'b0}, a);
        chk("R1 mismatch nack", 32'(a), 32'd0);
        send_byte(8'h00, a);
        chk("R1 ignored sub", 32'(a), 32'd0);
        send_byte(8'hEE, a);
        chk("R1 ignored data", 32'(a), 32'd0);
        bus_stop();
        check_all("R1 mismatch no store");

        // R7 START in the middle of a data byte
        bus_start();
        send_byte({DEV, 1'b0}, a);
        send_byte(8'h00, a);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        bus_start();
        send_byte({DEV, 1'b0}, a);
        chk("R7 restart address ack", 32'(a), 32'd1);
        send_byte(8'h01, a);
        send_byte(8'h77, a);
        chk("R7 restart data ack", 32'(a), 32'd1);
        model[1] = 8'h77;
        bus_stop();
        check_all("R7 fragment dropped");
        // R7 STOP right after subaddress, then a fresh write
        bus_start();
        send_byte({DEV, 1'b0}, a);
        send_byte(8'h00, a);
        bus_stop();
        wdat[0] = 8'h5C;
        wr_txn(8'h00, 1, acks);
        chk("R7 after stop acks", 32'(acks[2:0]), 32'b111);
        check_all("R7 after stop store");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule